// File: doc/BRIEF.md
# Receive Mute and Wakeup Filter

This block sits behind a serial character receiver. It decides which received characters are placed in the receive buffer that software reads. The receiver hands it one strobe for each finished character, together with the data word. It also gets a second strobe when an idle frame has been seen on the line. Software can put the node to sleep through a mute-request bit. While the node is muted, received characters are dropped. No buffer flag is raised and no interrupt or DMA request is issued for them.

There are two ways to wake the node. In idle-line mode, any idle frame ends mute. In address-mark mode, characters whose flag bit is set are addresses. The flag bit is the top bit of the frame: bit 8 for 9-bit frames and bit 7 for 8-bit frames. An address that names this node ends mute, and that address character is itself buffered. An address that names another node puts the node into mute without buffering it. Software writes to the mute-request bit only take effect while the buffer is empty. A read strobe empties the buffer.

Top module: `rx_wake_filter`

## Requirements
- R1: After reset, `mute` is 0, `buf_full` is 0, `rx_req` is 0 and `buf_char` is 0.
- R2: With `wake_addr_mode`=1, a character is an address when bit 8 is 1 (`long_frame`=1) or when bit 7 is 1 (`long_frame`=0). The target address is held in bits 3:0 and is compared with `node_id`. When the flag bit is 0, the character is data, whatever the other top bit holds.
- R3: In address-mark mode, an address character that does not match sets `mute` in the next cycle. It does not change `buf_full` or `buf_char` and raises no `rx_req`.
- R4: In address-mark mode, an address character that matches clears `mute` in the next cycle. It is also stored in `buf_char` with `buf_full`=1.
- R5: While `mute`=1, a data character leaves `buf_full` and `buf_char` unchanged and raises no `rx_req`.
- R6: In idle-line mode (`wake_addr_mode`=0), an accepted software write of 1 sets `mute`. An `rx_idle` strobe clears `mute` in the next cycle.
- R7: In address-mark mode, `rx_idle` has no effect on `mute`. In idle-line mode, the flag bit has no address meaning: an unmuted character with bit 8 or bit 7 set is buffered and leaves `mute` at 0.
- R8: A software write (`mute_wr_en`) loads `mute_wr_val` into `mute` only when `buf_full` is 0. While `buf_full` is 1, the write is ignored.
- R9: A character that is not dropped is stored in `buf_char` and sets `buf_full` in the next cycle, even if the buffer already held data. A `buf_rd` strobe with no new character clears `buf_full`.
- R10: `rx_req` is high for exactly one cycle, in the cycle in which `buf_full` changes from 0 to 1. It stays low when a new character overwrites a buffer that is already full.
- R11: In the same cycle, a hardware mute change takes precedence over a software write. Such a change is an address character in address-mark mode or `rx_idle` in idle-line mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe: a character was received |
| rx_char | input | 9 | Received character, bit 8 used only in 9-bit frames |
| rx_idle | input | 1 | One-cycle strobe: an idle frame was detected |
| wake_addr_mode | input | 1 | 1 = address-mark wakeup, 0 = idle-line wakeup |
| long_frame | input | 1 | 1 = 9-bit frames, 0 = 8-bit frames |
| node_id | input | 4 | Address of this node |
| mute_wr_en | input | 1 | Software write strobe for the mute-request bit |
| mute_wr_val | input | 1 | Value written to the mute-request bit |
| buf_rd | input | 1 | Software read of the buffered character |
| buf_full | output | 1 | Receive buffer holds unread data |
| buf_char | output | 9 | Buffered character |
| rx_req | output | 1 | One-cycle interrupt/DMA request |
| mute | output | 1 | Current mute-request state |

## Verification
Several rules are checked on every cycle by assertions:
- a mismatching address always mutes the node and a matching one always wakes it;
- `rx_idle` wakes the node in idle-line mode and leaves it alone in address-mark mode;
- writes are blocked while the buffer is full;
- muted data characters leave the buffer untouched;
- the request appears only on a rising buffer flag.

Some behaviour only shows in the bench's scenarios. These include the choice of flag bit for each frame length, a 9-bit character whose bit 7 is set but which still counts as data, overwriting a full buffer, and the outcome when a hardware event and a software write collide. The bench's behavioural model, run against long random traffic, covers the interaction of the two wakeup modes.

// File: rtl/rx_wake_pkg.sv
package rx_wake_pkg;

    typedef enum logic [1:0] {
        KIND_DATA      = 2'd0,
        KIND_ADDR_HIT  = 2'd1,
        KIND_ADDR_MISS = 2'd2
    } char_kind_e;

endpackage

// File: rtl/rx_wake_classify.sv
module rx_wake_classify
    import rx_wake_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic [DATA_W-1:0] char_in,
    input  logic              addr_mode,
    input  logic              wide,
    input  logic [ADDR_W-1:0] own_addr,
    output char_kind_e        kind
);
    localparam int FLAG_WIDE   = DATA_W - 1;
    localparam int FLAG_NARROW = DATA_W - 2;

    logic flag_bit;
    logic addr_hit;

    always_comb begin
        flag_bit = wide ? char_in[FLAG_WIDE] : char_in[FLAG_NARROW];
        addr_hit = (char_in[ADDR_W-1:0] == own_addr);
        if (!addr_mode || !flag_bit) begin
            kind = KIND_DATA;
        end else if (addr_hit) begin
            kind = KIND_ADDR_HIT;
        end else begin
            kind = KIND_ADDR_MISS;
        end
    end

endmodule

// File: rtl/rx_wake_mute_ctrl.sv
module rx_wake_mute_ctrl
    import rx_wake_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       char_stb,
    input  char_kind_e kind,
    input  logic       idle_stb,
    input  logic       addr_mode,
    input  logic       sw_wr,
    input  logic       sw_val,
    input  logic       buf_busy,
    output logic       deliver,
    output logic       mute_o
);
    typedef struct packed {
        logic mute;
    } mute_state_t;

    mute_state_t st_d, st_q;
    logic        hw_touch;

    always_comb begin
        st_d     = st_q;
        deliver  = 1'b0;
        hw_touch = 1'b0;
        if (char_stb) begin
            unique case (kind)
                KIND_ADDR_HIT: begin
                    st_d.mute = 1'b0;
                    deliver   = 1'b1;
                    hw_touch  = 1'b1;
                end
                KIND_ADDR_MISS: begin
                    st_d.mute = 1'b1;
                    hw_touch  = 1'b1;
                end
                default: begin
                    deliver = !st_q.mute;
                end
            endcase
        end
        if (!addr_mode && idle_stb) begin
            st_d.mute = 1'b0;
            hw_touch  = 1'b1;
        end
        if (!hw_touch && sw_wr && !buf_busy) begin
            st_d.mute = sw_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mute_o = st_q.mute;

    AST_MISS_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        char_stb && kind == KIND_ADDR_MISS |=> mute_o); // R3
    AST_HIT_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        char_stb && kind == KIND_ADDR_HIT |=> !mute_o); // R4
    AST_IDLE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_mode && idle_stb |=> !mute_o); // R6
    AST_ADDR_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        addr_mode && idle_stb && !char_stb && !sw_wr |=> $stable(mute_o)); // R7
    AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr && buf_busy && !char_stb && !idle_stb |=> $stable(mute_o)); // R8

endmodule

// File: rtl/rx_wake_buffer.sv
module rx_wake_buffer #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deliver,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o,
    output logic              req_o
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
        logic              req;
    } buf_state_t;

    buf_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (deliver) begin
            st_d.data = wdata;
            st_d.full = 1'b1;
            st_d.req  = !st_q.full;
        end else if (rd) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full_o = st_q.full;
    assign data_o = st_q.data;
    assign req_o  = st_q.req;

    AST_REQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> full_o && !$past(full_o)); // R10
    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !deliver |=> !full_o); // R9
    AST_DELIVER_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        deliver |=> full_o && data_o == $past(wdata)); // R9

endmodule

// File: rtl/rx_wake_filter.sv
module rx_wake_filter
    import rx_wake_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_char,
    input  logic              rx_idle,
    input  logic              wake_addr_mode,
    input  logic              long_frame,
    input  logic [ADDR_W-1:0] node_id,
    input  logic              mute_wr_en,
    input  logic              mute_wr_val,
    input  logic              buf_rd,
    output logic              buf_full,
    output logic [DATA_W-1:0] buf_char,
    output logic              rx_req,
    output logic              mute
);
    char_kind_e kind;
    logic       deliver;

    rx_wake_classify #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_classify (
        .char_in   (rx_char),
        .addr_mode (wake_addr_mode),
        .wide      (long_frame),
        .own_addr  (node_id),
        .kind      (kind)
    );

    rx_wake_mute_ctrl u_mute (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_stb  (rx_valid),
        .kind      (kind),
        .idle_stb  (rx_idle),
        .addr_mode (wake_addr_mode),
        .sw_wr     (mute_wr_en),
        .sw_val    (mute_wr_val),
        .buf_busy  (buf_full),
        .deliver   (deliver),
        .mute_o    (mute)
    );

    rx_wake_buffer #(
        .DATA_W (DATA_W)
    ) u_buffer (
        .clk     (clk),
        .rst_n   (rst_n),
        .deliver (deliver),
        .wdata   (rx_char),
        .rd      (buf_rd),
        .full_o  (buf_full),
        .data_o  (buf_char),
        .req_o   (rx_req)
    );

    AST_MUTED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        mute && rx_valid && kind == KIND_DATA && !buf_rd
        |=> !rx_req && $stable(buf_data_chk())); // R5

    function automatic logic [DATA_W:0] buf_data_chk();
        return {buf_full, buf_char};
    endfunction

endmodule

// File: tb/rx_wake_filter_test.sv
module rx_wake_filter_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 9;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [DW-1:0] rx_char = '0;
    logic          rx_idle = 1'b0;
    logic          wake_addr_mode = 1'b1;
    logic          long_frame = 1'b0;
    logic [AW-1:0] node_id = 4'd1;
    logic          mute_wr_en = 1'b0;
    logic          mute_wr_val = 1'b0;
    logic          buf_rd = 1'b0;
    logic          buf_full;
    logic [DW-1:0] buf_char;
    logic          rx_req;
    logic          mute;

    int total = 0;
    int bad = 0;
    string cur_tag = "R1";

    rx_wake_filter #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
        .rx_idle(rx_idle), .wake_addr_mode(wake_addr_mode), .long_frame(long_frame),
        .node_id(node_id), .mute_wr_en(mute_wr_en), .mute_wr_val(mute_wr_val),
        .buf_rd(buf_rd), .buf_full(buf_full), .buf_char(buf_char),
        .rx_req(rx_req), .mute(mute)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    logic          m_mute = 1'b0;
    logic          m_full = 1'b0;
    logic [DW-1:0] m_data = '0;
    logic          m_req = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mute = 0; m_full = 0; m_data = '0; m_req = 0;
        end else begin
            bit is_addr, hit, take, hw, nm;
            is_addr = wake_addr_mode && (long_frame ? rx_char[8] : rx_char[7]);
            hit = (rx_char[3:0] == node_id);
            nm = m_mute; take = 0; hw = 0;
            if (rx_valid) begin
                if (is_addr) begin
                    hw = 1;
                    if (hit) begin nm = 0; take = 1; end
                    else nm = 1;
                end else take = !m_mute;
            end
            if (!wake_addr_mode && rx_idle) begin nm = 0; hw = 1; end
            if (!hw && mute_wr_en && !m_full) nm = mute_wr_val;
            m_req = take && !m_full;
            if (take) begin m_full = 1; m_data = rx_char; end
            else if (buf_rd) m_full = 0;
            m_mute = nm;
        end
    end

    task automatic chk(string tag, string what, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_tag, "model mute", mute, m_mute);
            chk(cur_tag, "model full", buf_full, m_full);
            chk(cur_tag, "model req", rx_req, m_req);
            chk(cur_tag, "model data", buf_char, m_data);
        end
    end

    // drive one cycle of stimulus starting at a negedge; returns at the next negedge
    task automatic cyc(bit v, logic [DW-1:0] c, bit idl, bit wr, bit wv, bit rd);
        rx_valid = v; rx_char = c; rx_idle = idl;
        mute_wr_en = wr; mute_wr_val = wv; buf_rd = rd;
        @(negedge clk);
        rx_valid = 0; rx_idle = 0; mute_wr_en = 0; buf_rd = 0;
    endtask

    task automatic send(logic [DW-1:0] c);
        cyc(1, c, 0, 0, 0, 0);
    endtask

    task automatic do_read();
        cyc(0, '0, 0, 0, 0, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_tag = "R1";
        chk("R1", "mute", mute, 0);
        chk("R1", "full", buf_full, 0);
        chk("R1", "req", rx_req, 0);
        chk("R1", "data", buf_char, 0);

        // address-mark mode, 8-bit frames, node 1
        cur_tag = "R3";
        send(9'h080);
        chk("R3", "mute after miss", mute, 1);
        chk("R3", "full after miss", buf_full, 0);
        chk("R3", "req after miss", rx_req, 0);
        cur_tag = "R5";
        send(9'h011);
        chk("R5", "muted data dropped", buf_full, 0);
        chk("R5", "muted data no req", rx_req, 0);
        cur_tag = "R4";
        send(9'h081);
        chk("R4", "mute after hit", mute, 0);
        chk("R4", "hit buffered", buf_char, 9'h081);
        chk("R10", "req on rise", rx_req, 1);
        @(negedge clk);
        chk("R10", "req single cycle", rx_req, 0);
        cur_tag = "R9";
        send(9'h022);
        chk("R9", "overwrite data", buf_char, 9'h022);
        chk("R9", "overwrite keeps full", buf_full, 1);
        chk("R10", "no req on overwrite", rx_req, 0);
        do_read();
        chk("R9", "read clears", buf_full, 0);

        // 9-bit frames
        cur_tag = "R2";
        long_frame = 1;
        send(9'h082);
        chk("R2", "bit7 set is data in 9-bit", buf_full, 1);
        chk("R2", "no mute on 9-bit data", mute, 0);
        do_read();
        send(9'h102);
        chk("R2", "bit8 address miss", mute, 1);
        chk("R2", "miss not buffered", buf_full, 0);
        send(9'h101);
        chk("R2", "bit8 address hit", mute, 0);
        chk("R2", "hit buffered", buf_char, 9'h101);

        // software write gating
        cur_tag = "R8";
        cyc(0, '0, 0, 1, 1, 0);
        chk("R8", "write ignored when full", mute, 0);
        do_read();
        cyc(0, '0, 0, 1, 1, 0);
        chk("R8", "write accepted when empty", mute, 1);
        cur_tag = "R7";
        cyc(0, '0, 1, 0, 0, 0);
        chk("R7", "idle ignored in addr mode", mute, 1);

        // idle-line mode
        wake_addr_mode = 0;
        send(9'h1FF);
        chk("R5", "muted char dropped idle mode", buf_full, 0);
        cur_tag = "R6";
        cyc(0, '0, 1, 0, 0, 0);
        chk("R6", "idle frame wakes", mute, 0);
        cur_tag = "R7";
        send(9'h1F3);
        chk("R7", "flag char is data in idle mode", buf_full, 1);
        chk("R7", "no mute from flag", mute, 0);
        do_read();
        cur_tag = "R6";
        cyc(0, '0, 0, 1, 1, 0);
        chk("R6", "sw write mutes", mute, 1);
        cur_tag = "R11";
        cyc(0, '0, 1, 1, 1, 0);
        chk("R11", "idle beats write", mute, 0);
        wake_addr_mode = 1;
        cyc(1, 9'h105, 0, 1, 0, 0);
        chk("R11", "miss beats write", mute, 1);

        // random traffic against the model
        cur_tag = "R9";
        for (int i = 0; i < 3000; i++) begin
            logic [DW-1:0] c;
            if (i % 500 == 0) begin
                wake_addr_mode = $urandom_range(0, 1);
                long_frame = $urandom_range(0, 1);
                node_id = 4'($urandom_range(0, 15));
            end
            c = DW'($urandom_range(0, 511));
            if ($urandom_range(0, 2) == 0) c[3:0] = node_id;
            cyc($urandom_range(0, 2) == 0, c, $urandom_range(0, 9) == 0,
                $urandom_range(0, 7) == 0, $urandom_range(0, 1), $urandom_range(0, 3) == 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule